// File: doc/BRIEF.md
# Token-Driven Dual-Port Memory Element

This block is a processing element for a dataflow array, built around a dual-port memory. It does nothing on its own: every access is started by a token that arrives over a valid/ready channel. In addressable mode, a token on the read-address channel fetches one stored word, and that word leaves as a token on the output channel. A write needs two tokens: one on the write-address channel and one on the data-input channel. Both are consumed in the same cycle.

In queue mode the same storage works as a first-in first-out buffer. Tokens enter on the data-input channel and leave in arrival order on the output channel. A level input selects the mode and can be changed while the block runs. A separate configuration write port fills the storage directly, so the element can act as a lookup table for a function before any token arrives.

Top module: `token_ram_pe`

## Requirements
- R1: Synchronous reset with `rst` high leaves `dout_valid` low. When `cfg_fifo_mode` is 0 (addressable mode), `raddr_ready` is high in the first cycle after reset.
- R2: In addressable mode, a read-address token accepted at a clock edge makes `dout_valid` high in the next cycle. `dout_tok` then holds the word stored at that address, and exactly one output token is produced per accepted address.
- R3: The memory index is taken from the low log2(DEPTH) bits of an address token. The upper bits have no effect.
- R4: A write happens only when `waddr_valid` and `din_valid` are both high, and both channels show ready in that same cycle. If only one of the two is offered, its ready stays low and the memory is unchanged.
- R5: If a read and a write target the same index in the same cycle, the read returns the word stored before the write.
- R6: While `dout_valid` is high and `dout_ready` is low, `dout_tok` stays stable and no read-address token is accepted.
- R7: When `cfg_load_en` is high, `cfg_load_data` is written at `cfg_load_addr`. In that cycle no token write is accepted (`waddr_ready` and `din_ready` are low).
- R8: When `cfg_fifo_mode` is 1 (queue mode), tokens leave in the order they entered. The queue holds DEPTH+1 tokens: DEPTH in memory and one in the output buffer. `din_ready` is low while the memory part is full.
- R9: In queue mode, `dout_valid` is low while the queue is empty. Tokens may enter and leave in the same cycle.
- R10: When `cfg_fifo_mode` differs from the current mode, `dout_valid` and all ready outputs are low for that cycle, the pending output token is discarded, and the queue restarts empty.
- R11: In queue mode, `raddr_ready` and `waddr_ready` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_mode | input | 1 | 0 selects addressable mode, 1 selects queue mode |
| cfg_load_en | input | 1 | Configuration write strobe |
| cfg_load_addr | input | log2(DEPTH) | Configuration write index |
| cfg_load_data | input | DW | Configuration write word |
| raddr_valid | input | 1 | Read-address token offered |
| raddr_ready | output | 1 | Read-address token accepted |
| raddr_tok | input | DW | Read-address token |
| waddr_valid | input | 1 | Write-address token offered |
| waddr_ready | output | 1 | Write-address token accepted |
| waddr_tok | input | DW | Write-address token |
| din_valid | input | 1 | Data-input token offered |
| din_ready | output | 1 | Data-input token accepted |
| din_tok | input | DW | Write data (addressable) or queue entry (queue) |
| dout_valid | output | 1 | Output token available |
| dout_ready | input | 1 | Output token consumed |
| dout_tok | output | DW | Output token |

## Verification
The assertions assume the producers follow valid/ready rules: an offered token's valid never waits for ready. They also assume `cfg_load_en` is never held high indefinitely while token writes are pending. The stimulus drives every channel from tasks that hold a token until the matching ready is seen at a sampling point. It raises configuration loads only for single cycles, and changes the mode only between token sequences. That way, each mode switch lands on a known queue content.

// File: rtl/tram_pkg.sv
package tram_pkg;
  typedef enum logic {
    MODE_RAM  = 1'b0,
    MODE_FIFO = 1'b1
  } pe_mode_e;
endpackage

// File: rtl/tram_dpram.sv
// Simple dual-port storage: one write port, one registered read port.
module tram_dpram #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Separate process: a same-index read observes the pre-write word.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tram_fifo_ctl.sv
// Pointer and occupancy tracking for queue mode.
module tram_fifo_ctl #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          full,
  output logic          empty
);
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] wptr_q, rptr_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push) wptr_q <= bump(wptr_q);
      if (pop)  rptr_q <= bump(rptr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R8
  push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R9
  pop_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R8
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/tram_wport.sv
// Write-port selection: configuration load, then token pair, then queue push.
module tram_wport #(
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic          tok_we,
  input  logic [AW-1:0] tok_addr,
  input  logic [DW-1:0] tok_data,
  input  logic          q_we,
  input  logic [AW-1:0] q_addr,
  input  logic [DW-1:0] q_data,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  always_comb begin
    we   = 1'b1;
    addr = load_addr;
    data = load_data;
    if (!load_en) begin
      if (tok_we) begin
        addr = tok_addr;
        data = tok_data;
      end else if (q_we) begin
        addr = q_addr;
        data = q_data;
      end else begin
        we = 1'b0;
      end
    end
  end
endmodule

// File: rtl/token_ram_pe.sv
module token_ram_pe
  import tram_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_fifo_mode,
  input  logic          cfg_load_en,
  input  logic [AW-1:0] cfg_load_addr,
  input  logic [DW-1:0] cfg_load_data,
  input  logic          raddr_valid,
  output logic          raddr_ready,
  input  logic [DW-1:0] raddr_tok,
  input  logic          waddr_valid,
  output logic          waddr_ready,
  input  logic [DW-1:0] waddr_tok,
  input  logic          din_valid,
  output logic          din_ready,
  input  logic [DW-1:0] din_tok,
  output logic          dout_valid,
  input  logic          dout_ready,
  output logic [DW-1:0] dout_tok
);
  pe_mode_e mode_q, mode_req;
  logic flush, is_ram, is_fifo;
  logic out_vld_q;
  logic pair_ok, tok_we, q_push, fetch_ram, fetch_fifo, rd_en;
  logic q_full, q_empty;
  logic [AW-1:0] q_wptr, q_rptr, rd_addr;
  logic mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic unused_tok_hi;

  assign mode_req = pe_mode_e'(cfg_fifo_mode);
  assign flush    = (mode_req != mode_q);
  assign is_ram   = !flush && (mode_q == MODE_RAM);
  assign is_fifo  = !flush && (mode_q == MODE_FIFO);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RAM;
    else     mode_q <= mode_req;
  end

  // Token handshakes
  assign pair_ok     = is_ram && !cfg_load_en;
  assign raddr_ready = is_ram && !out_vld_q;
  assign waddr_ready = pair_ok && din_valid;
  assign din_ready   = (pair_ok && waddr_valid) || (is_fifo && !q_full && !cfg_load_en);

  assign tok_we     = waddr_valid && waddr_ready;
  assign q_push     = is_fifo && din_valid && din_ready;
  assign fetch_ram  = raddr_valid && raddr_ready;
  assign fetch_fifo = is_fifo && !q_empty && !out_vld_q;
  assign rd_en      = fetch_ram || fetch_fifo;
  assign rd_addr    = is_fifo ? q_rptr : raddr_tok[AW-1:0];

  assign unused_tok_hi = ^{raddr_tok[DW-1:AW], waddr_tok[DW-1:AW]};

  tram_fifo_ctl #(.DEPTH(DEPTH)) u_qctl (
    .clk   (clk),
    .rst   (rst),
    .clr   (flush),
    .push  (q_push),
    .pop   (fetch_fifo),
    .wptr  (q_wptr),
    .rptr  (q_rptr),
    .full  (q_full),
    .empty (q_empty)
  );

  tram_wport #(.DW(DW), .AW(AW)) u_wsel (
    .load_en   (cfg_load_en),
    .load_addr (cfg_load_addr),
    .load_data (cfg_load_data),
    .tok_we    (tok_we),
    .tok_addr  (waddr_tok[AW-1:0]),
    .tok_data  (din_tok),
    .q_we      (q_push),
    .q_addr    (q_wptr),
    .q_data    (din_tok),
    .we        (mem_we),
    .addr      (mem_waddr),
    .data      (mem_wdata)
  );

  tram_dpram #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (mem_rdata)
  );

  // Output buffer: the memory read register doubles as the token register.
  always_ff @(posedge clk) begin
    if (rst || flush)              out_vld_q <= 1'b0;
    else if (rd_en)                out_vld_q <= 1'b1;
    else if (out_vld_q && dout_ready) out_vld_q <= 1'b0;
  end

  assign dout_valid = out_vld_q && !flush;
  assign dout_tok   = mem_rdata;

  // R2
  read_yields_token_chk: assert property (@(posedge clk) disable iff (rst)
    (raddr_valid && raddr_ready) |=> (dout_valid || flush));
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_valid && !dout_ready) |=> (flush || (dout_valid && $stable(dout_tok))));
  // R4
  pair_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (waddr_valid && waddr_ready) |-> (din_valid && din_ready));
  // R10
  flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !dout_valid);
  // R11
  fifo_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_FIFO && !flush) |-> (!raddr_ready && !waddr_ready));
endmodule

// File: tb/sim_token_ram_pe.sv
module sim_token_ram_pe;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_fifo_mode = 1'b0;
  logic cfg_load_en = 1'b0;
  logic [AW-1:0] cfg_load_addr = '0;
  logic [DW-1:0] cfg_load_data = '0;
  logic raddr_valid = 1'b0, waddr_valid = 1'b0, din_valid = 1'b0, dout_ready = 1'b0;
  logic [DW-1:0] raddr_tok = '0, waddr_tok = '0, din_tok = '0;
  logic raddr_ready, waddr_ready, din_ready, dout_valid;
  logic [DW-1:0] dout_tok;

  int nchk = 0;
  int nerr = 0;
  int ps = 0;
  int pp = 0;

  always #10 clk = ~clk;

  token_ram_pe #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [DW-1:0] a, input logic [DW-1:0] d);
    waddr_tok = a; din_tok = d; waddr_valid = 1'b1; din_valid = 1'b1;
    @(negedge clk);
    while (!waddr_ready) @(negedge clk);
    after_edge();
    waddr_valid = 1'b0; din_valid = 1'b0;
  endtask

  task automatic do_read(input logic [DW-1:0] a, output logic [DW-1:0] d);
    raddr_tok = a; raddr_valid = 1'b1;
    @(negedge clk);
    while (!raddr_ready) @(negedge clk);
    after_edge();
    raddr_valid = 1'b0;
    @(negedge clk);
    check_eq("R2 latency", 32'(dout_valid), 32'd1);
    d = dout_tok;
    dout_ready = 1'b1;
    after_edge();
    dout_ready = 1'b0;
  endtask

  function automatic logic [DW-1:0] lut_val(input int i);
    return DW'(i * i + 3);
  endfunction

  // Queue traffic: push when (c % pm) < pn, pop when (c % qm) < qn.
  task automatic run_q(input int cycles, input int pm, input int pn, input int qm, input int qn);
    for (int c = 0; c < cycles; c++) begin
      din_valid  = ((c % pm) < pn);
      din_tok    = DW'(16'hA000 + ps);
      dout_ready = ((c % qm) < qn);
      @(negedge clk);
      if (din_valid && din_ready) ps++;
      if (dout_valid) begin
        if (pp >= ps) check_eq("R9 valid while empty", 32'(pp), 32'(ps + 1));
        if (dout_ready) begin
          check_eq("R8 order", 32'(dout_tok), 32'(16'hA000 + pp));
          pp++;
        end
      end
      after_edge();
    end
    din_valid = 1'b0; dout_ready = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    repeat (3) after_edge();
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 dout_valid", 32'(dout_valid), 32'd0);
    check_eq("R1 raddr_ready", 32'(raddr_ready), 32'd1);

    // R7: preload a lookup table, then read it back
    for (int i = 0; i < DEPTH; i++) begin
      after_edge();
      cfg_load_en = 1'b1; cfg_load_addr = AW'(i); cfg_load_data = lut_val(i);
    end
    after_edge();
    cfg_load_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      do_read(DW'(i), rd);
      check_eq("R7 lookup", 32'(rd), 32'(lut_val(i)));
    end

    // R7: load blocks a token write in the same cycle
    cfg_load_en = 1'b1; cfg_load_addr = 4'd3; cfg_load_data = 16'h3333;
    waddr_tok = 16'd3; din_tok = 16'hBEEF; waddr_valid = 1'b1; din_valid = 1'b1;
    @(negedge clk);
    check_eq("R7 waddr_ready during load", 32'(waddr_ready), 32'd0);
    check_eq("R7 din_ready during load", 32'(din_ready), 32'd0);
    after_edge();
    cfg_load_en = 1'b0; waddr_valid = 1'b0; din_valid = 1'b0;
    do_read(16'd3, rd);
    check_eq("R7 load wins", 32'(rd), 32'h3333);

    // R2/R3: token writes with upper address bits set, sweep all indices
    for (int i = 0; i < DEPTH; i++) do_write(DW'(i + 16 * (i + 1)), DW'(i * 7 + 16'h100));
    for (int i = 0; i < DEPTH; i++) begin
      do_read(DW'(i + 16 * (15 - i)), rd);
      check_eq("R3 low index bits", 32'(rd), 32'(i * 7 + 16'h100));
    end

    // R4: address alone or data alone does not write
    waddr_tok = 16'd9; waddr_valid = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check_eq("R4 waddr_ready without data", 32'(waddr_ready), 32'd0);
      after_edge();
    end
    waddr_valid = 1'b0;
    din_tok = 16'h5555; din_valid = 1'b1;
    @(negedge clk);
    check_eq("R4 din_ready without address", 32'(din_ready), 32'd0);
    after_edge();
    din_valid = 1'b0;
    do_read(16'd9, rd);
    check_eq("R4 memory unchanged", 32'(rd), 32'(9 * 7 + 16'h100));

    // R5: read and write of the same index in one cycle
    raddr_tok = 16'd5; raddr_valid = 1'b1;
    waddr_tok = 16'd5; din_tok = 16'h7777; waddr_valid = 1'b1; din_valid = 1'b1;
    @(negedge clk);
    check_eq("R5 both accepted", 32'({raddr_ready, waddr_ready}), 32'd3);
    after_edge();
    raddr_valid = 1'b0; waddr_valid = 1'b0; din_valid = 1'b0;
    @(negedge clk);
    check_eq("R5 old data", 32'(dout_tok), 32'(5 * 7 + 16'h100));
    dout_ready = 1'b1;
    after_edge();
    dout_ready = 1'b0;
    do_read(16'd5, rd);
    check_eq("R5 new data later", 32'(rd), 32'h7777);

    // R6: held output blocks further reads
    raddr_tok = 16'd2; raddr_valid = 1'b1;
    after_edge();
    raddr_tok = 16'd4;
    repeat (3) begin
      @(negedge clk);
      check_eq("R6 raddr_ready while held", 32'(raddr_ready), 32'd0);
      check_eq("R6 dout_tok held", 32'(dout_tok), 32'(2 * 7 + 16'h100));
      after_edge();
    end
    raddr_valid = 1'b0; dout_ready = 1'b1;
    after_edge();
    dout_ready = 1'b0;

    // Switch to queue mode
    cfg_fifo_mode = 1'b1;
    raddr_valid = 1'b1; waddr_valid = 1'b1; din_valid = 1'b1; din_tok = 16'h1;
    @(negedge clk);
    check_eq("R10 readies low on switch", 32'({raddr_ready, waddr_ready, din_ready}), 32'd0);
    after_edge();
    @(negedge clk);
    check_eq("R11 raddr_ready in queue", 32'(raddr_ready), 32'd0);
    check_eq("R11 waddr_ready in queue", 32'(waddr_ready), 32'd0);
    raddr_valid = 1'b0; waddr_valid = 1'b0; din_valid = 1'b0;
    after_edge();
    ps = 0; pp = 0;

    // R8: fill without popping
    run_q(40, 1, 1, 1, 0);
    check_eq("R8 capacity", 32'(ps), 32'(DEPTH + 1));
    din_valid = 1'b1;
    @(negedge clk);
    check_eq("R8 din_ready when full", 32'(din_ready), 32'd0);
    after_edge();
    din_valid = 1'b0;
    // R9: drain
    run_q(60, 1, 0, 1, 1);
    check_eq("R9 drained count", 32'(pp), 32'(DEPTH + 1));
    @(negedge clk);
    check_eq("R9 empty valid low", 32'(dout_valid), 32'd0);
    after_edge();
    // R9: concurrent traffic in several patterns
    run_q(200, 3, 2, 2, 1);
    run_q(200, 5, 1, 4, 3);
    run_q(150, 2, 2, 7, 1);
    run_q(300, 1, 0, 1, 1);
    check_eq("R9 all delivered", 32'(pp), 32'(ps));

    // R10: switch away with pending tokens, then back
    run_q(8, 1, 1, 1, 0);
    @(negedge clk);
    check_eq("R10 token pending", 32'(dout_valid), 32'd1);
    after_edge();
    cfg_fifo_mode = 1'b0;
    @(negedge clk);
    check_eq("R10 discard on switch", 32'(dout_valid), 32'd0);
    after_edge();
    cfg_fifo_mode = 1'b1;
    after_edge();
    dout_ready = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check_eq("R10 queue restarted empty", 32'(dout_valid), 32'd0);
      after_edge();
    end
    dout_ready = 1'b0;
    ps = 0; pp = 0;
    run_q(30, 1, 1, 2, 1);
    run_q(40, 1, 0, 1, 1);
    check_eq("R10 queue after restart", 32'(pp), 32'(ps));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule